// File: doc/BRIEF.md
# I2C Master Transfer Abort Cause Recorder

This block keeps a sticky record of why an I2C master transfer was aborted. The protocol engine reports each abort reason as a single-cycle pulse on its own line of a cause vector. The block ORs every pulse into an abort-cause register and holds a pending abort interrupt while any cause is recorded. On the first cause of an abort episode it emits a one-cycle strobe that tells the transmit and receive FIFOs to discard their contents.

Software reads the cause register through the normal register path, then reads one dedicated clear address. That read empties the cause register and drops the interrupt. A summary flag reports whether any cause in the no-acknowledge group is recorded. Detecting the causes on the bus is left to the protocol engine.

Top module: `abort_capture`

## Requirements
- R1: A pulse on a supported cause input sets the same bit of `abort_src` at the next clock edge. The supported positions are 0 (7-bit address not acknowledged), 1 (first 10-bit address byte not acknowledged), 2 (second 10-bit address byte not acknowledged), 3 (data not acknowledged), 4 (general call not acknowledged), 5 (read after general call), 7 (start byte acknowledged), 9 (start byte while restart disabled), 10 (10-bit read while restart disabled), 11 (master disabled) and 12 (arbitration lost).
- R2: Recorded bits are sticky and accumulate by OR. Several causes in one cycle, or in separate cycles, are all kept until a clear.
- R3: Bit positions 6, 8 and 13 to 15 always read 0. A pulse on those inputs changes neither `abort_src`, `abort_irq` nor `fifo_flush`.
- R4: `abort_irq` is 1 exactly when at least one bit of `abort_src` is set.
- R5: A cycle with `rd_en`=1 and `rd_addr` equal to `CLR_ADDR` (default 8'h2A) clears `abort_src` and `abort_irq` at the next edge. The register keeps its value up to that edge, so it can be read beforehand.
- R6: A read of any other address, or `rd_addr`=`CLR_ADDR` with `rd_en`=0, leaves `abort_src` and `abort_irq` unchanged.
- R7: A cause pulse in the same cycle as a clear read is recorded. After the edge only the new causes remain set.
- R8: `fifo_flush` is high for exactly one cycle, the cycle after a supported cause is latched while no abort was pending or while the pending abort was being cleared.
- R9: Further causes that arrive while an abort is already pending, with no clear in the same cycle, produce no `fifo_flush` pulse.
- R10: `noack_any` is 1 exactly when any of bits 0 to 4 of `abort_src` is set.
- R11: After reset, `abort_src`, `abort_irq`, `fifo_flush` and `noack_any` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cause_in | input | CAUSE_W (16) | Abort cause pulses from the protocol engine |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W (8) | Register read address |
| abort_src | output | CAUSE_W (16) | Sticky abort-cause register |
| abort_irq | output | 1 | Pending abort interrupt |
| fifo_flush | output | 1 | One-cycle strobe that flushes both data FIFOs |
| noack_any | output | 1 | Any no-acknowledge cause is recorded |

## Verification
Every piece of internal state is visible at the ports one cycle after it changes. A cause bit that is lost, never cleared or wrongly set shows in `abort_src` at the next edge. If the interrupt state disagrees with the cause register, `abort_irq` and `abort_src` contradict each other in that same cycle. A wrong pending state reveals itself through `fifo_flush`: the flush either goes missing when the first cause of a new abort arrives, or repeats on a later cause. The bench probes this right after clears, during clears that coincide with causes, and during piled-up causes.

// File: rtl/abort_cap_pkg.sv
// Package: shared constants and helpers for the abort cause recorder.
// Assumes the cause vector is at most 32 bits wide.
package abort_cap_pkg;
    localparam int MAX_CAUSE_W = 32;
    localparam int NOACK_HI    = 4;   // bits 0..NOACK_HI form the no-acknowledge group

    // Build the mask of supported cause positions (0..12 except 6 and 8).
    function automatic logic [MAX_CAUSE_W-1:0] cause_mask();
        logic [MAX_CAUSE_W-1:0] m;
        m = '0;
        for (int i = 0; i <= 12; i++) begin
            if (i != 6 && i != 8) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/abort_cause_reg.sv
// Module: sticky per-bit cause register. Each supported bit ORs in its pulse
// and is cleared by clr_i unless the pulse arrives in the same cycle.
// Assumes VALID marks the supported positions; other bits stay 0.
module abort_cause_reg #(
    parameter int                 CAUSE_W = 16,
    parameter logic [CAUSE_W-1:0] VALID   = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               clr_i,
    output logic [CAUSE_W-1:0] src_o
);
    logic [CAUSE_W-1:0] src_q;

    for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
        localparam bit KEEP = VALID[i];
        logic hit;
        assign hit = KEEP & cause_i[i];

        // Hold one cause bit: set by its pulse, cleared by a clear read.
        always_ff @(posedge clk) begin
            if (!rst_n)      src_q[i] <= 1'b0;
            else if (clr_i)  src_q[i] <= hit;
            else             src_q[i] <= src_q[i] | hit;
        end
    end

    assign src_o = src_q;
endmodule

// File: rtl/abort_event.sv
// Module: pending-abort interrupt and FIFO flush strobe generation.
// Assumes new_cause_i is already restricted to supported cause positions.
module abort_event (
    input  logic clk,
    input  logic rst_n,
    input  logic new_cause_i,
    input  logic clr_i,
    output logic irq_o,
    output logic flush_o
);
    logic irq_q;
    logic flush_q;

    // Track the pending abort: set by a cause, dropped by a clear read.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= new_cause_i | (irq_q & ~clr_i);
    end

    // Pulse flush once when a cause opens a new abort episode.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= new_cause_i & (~irq_q | clr_i);
    end

    assign irq_o   = irq_q;
    assign flush_o = flush_q;
endmodule

// File: rtl/abort_capture.sv
// Module: top of the abort cause recorder. Decodes the clear read, filters
// unsupported cause inputs and combines the register and event logic.
// Assumes cause pulses are synchronous to clk; CAUSE_W must be 13..32.
module abort_capture
    import abort_cap_pkg::*;
#(
    parameter int              CAUSE_W  = 16,
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h2A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] cause_in,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [CAUSE_W-1:0] abort_src,
    output logic               abort_irq,
    output logic               fifo_flush,
    output logic               noack_any
);
    localparam logic [MAX_CAUSE_W-1:0] FULL_MASK = cause_mask();
    localparam logic [CAUSE_W-1:0]     VALID     = FULL_MASK[CAUSE_W-1:0];

    logic clr;
    logic new_cause;

    assign clr       = rd_en && (rd_addr == CLR_ADDR);
    assign new_cause = |(cause_in & VALID);

    abort_cause_reg #(.CAUSE_W(CAUSE_W), .VALID(VALID)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cause_i(cause_in),
        .clr_i  (clr),
        .src_o  (abort_src)
    );

    abort_event u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .new_cause_i(new_cause),
        .clr_i      (clr),
        .irq_o      (abort_irq),
        .flush_o    (fifo_flush)
    );

    assign noack_any = |abort_src[NOACK_HI:0];
endmodule

// File: rtl/abort_capture_chk.sv
// Module: property checker for abort_capture, attached by bind below.
// Assumes the same parameters as the checked instance.
module abort_capture_chk #(
    parameter int                CAUSE_W  = 16,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h2A
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CAUSE_W-1:0] cause_in,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [CAUSE_W-1:0] abort_src,
    input logic               abort_irq,
    input logic               fifo_flush
);
    localparam logic [31:0]        M32  = abort_cap_pkg::cause_mask();
    localparam logic [CAUSE_W-1:0] MASK = M32[CAUSE_W-1:0];

    logic clr_rd;
    assign clr_rd = rd_en && (rd_addr == CLR_ADDR);

    assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_src & ~MASK) == '0);

    assert_irq_matches_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_irq == (abort_src != '0));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_rd |=> ((abort_src & $past(abort_src)) == $past(abort_src)));

    assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && ((cause_in & MASK) == '0)) |=> (abort_src == '0 && !abort_irq));

    assert_flush_needs_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> abort_irq);

    assert_no_reflush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_irq && !clr_rd) |=> !fifo_flush);
endmodule

bind abort_capture abort_capture_chk #(
    .CAUSE_W(CAUSE_W), .ADDR_W(ADDR_W), .CLR_ADDR(CLR_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cause_in(cause_in), .rd_en(rd_en),
    .rd_addr(rd_addr), .abort_src(abort_src), .abort_irq(abort_irq),
    .fifo_flush(fifo_flush)
);

// File: tb/abort_capture_bench.sv
`timescale 1ns/1ps
module abort_capture_bench;
    localparam logic [15:0] SUP   = 16'h1EBF;  // supported positions
    localparam logic [7:0]  CLRA  = 8'h2A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cause_in = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] abort_src;
    logic        abort_irq, fifo_flush, noack_any;

    int total = 0;
    int bad   = 0;
    logic [15:0] exp_src = '0;

    always #2 clk = ~clk;

    abort_capture u_abort_capture (
        .clk(clk), .rst_n(rst_n), .cause_in(cause_in), .rd_en(rd_en),
        .rd_addr(rd_addr), .abort_src(abort_src), .abort_irq(abort_irq),
        .fifo_flush(fifo_flush), .noack_any(noack_any)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus at a falling edge; return at the next one.
    task automatic cyc(input logic [15:0] c, input logic r, input logic [7:0] a);
        cause_in = c; rd_en = r; rd_addr = a;
        @(negedge clk);
        cause_in = '0; rd_en = 1'b0; rd_addr = '0;
        if (r && a == CLRA) exp_src = c & SUP;
        else                exp_src = exp_src | (c & SUP);
    endtask

    task automatic chk_all(input string req, input logic exp_flush);
        chk(req, abort_src, exp_src);
        chk(req, {15'd0, abort_irq}, {15'd0, exp_src != 0});
        chk(req, {15'd0, fifo_flush}, {15'd0, exp_flush});
        chk(req, {15'd0, noack_any}, {15'd0, |exp_src[4:0]});
    endtask

    task automatic t_reset;  // R11
        chk_all("R11", 1'b0);
    endtask

    task automatic t_single_bits;  // R1, R8, R5
        for (int i = 0; i < 16; i++) begin
            if (SUP[i]) begin
                cyc(16'(1) << i, 1'b0, 8'h00);
                chk_all("R1", 1'b1);
                cyc('0, 1'b1, CLRA);
                chk_all("R5", 1'b0);
            end
        end
    endtask

    task automatic t_unused;  // R3
        cyc(~SUP, 1'b0, 8'h00);
        chk_all("R3", 1'b0);
    endtask

    task automatic t_accumulate;  // R2, R9, R10
        cyc(16'h0820, 1'b0, 8'h00);  // bits 5 and 11 together
        chk_all("R2", 1'b1);
        cyc(16'h1000, 1'b0, 8'h00);
        chk_all("R9", 1'b0);
        cyc(16'h0008, 1'b0, 8'h00);
        chk_all("R10", 1'b0);
        cyc('0, 1'b0, 8'h00);
        chk_all("R2", 1'b0);
    endtask

    task automatic t_other_reads;  // R6
        cyc('0, 1'b1, 8'h2B);
        chk_all("R6", 1'b0);
        cyc('0, 1'b0, CLRA);
        chk_all("R6", 1'b0);
    endtask

    task automatic t_clear_collide;  // R7, R8
        cyc(16'h0200, 1'b1, CLRA);
        chk("R7", abort_src, 16'h0200);
        chk_all("R8", 1'b1);
        cyc('0, 1'b0, 8'h00);
        chk_all("R8", 1'b0);
        cyc('0, 1'b1, CLRA);
        chk_all("R5", 1'b0);
        cyc(16'h0004, 1'b1, CLRA);  // clear with cause when nothing pending
        chk_all("R7", 1'b1);
        cyc('0, 1'b1, CLRA);
        chk_all("R5", 1'b0);
    endtask

    initial begin : watchdog
        #400000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_bits();
        t_unused();
        t_accumulate();
        t_other_reads();
        t_clear_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule